// File: doc/BRIEF.md
# Microcontroller Parallel-Bus Bridge with In-Band Register Select

This block is the slave side of a small parallel bus that joins a microcontroller to a frame-formatting engine. The bus has no address lines. The host works with four pins: an active-low select strobe, a read/write line, a mode line that picks FIFO traffic or register traffic, and an 8-bit data path split into input, output and output-enable at the pad. In FIFO mode each strobe moves one byte with no address. A write pushes into a transmit FIFO, and a read pops from a receive FIFO. In register mode a write carries its own destination in the two top data bits, and its low six bits are the value. A register-mode read returns a status byte built from the FIFO flags.

On the engine side the transmit FIFO drains through a valid/ready output stream, and the receive FIFO fills from a valid/ready input stream. The output stream keeps `tx_valid` high and `tx_data` steady until the engine accepts a beat with `tx_ready`. The input stream lowers `rx_ready` while the receive FIFO is full. A beat offered during that time is counted as lost and flagged, so an engine that cannot stall is still caught. Every host pin passes through a two-flop synchronizer. An action takes place once, on the release edge of the strobe, and uses the data sampled while the strobe was still active. The six-bit configuration fields hold their values until reset or until they are written again.

Top module: `hostbus_bridge`

## Requirements
- R1: After reset all four configuration fields read zero. Both FIFOs are empty, `tx_valid` is low, and the status byte equals 8'h06.
- R2: A register-mode write stores data bits [5:0] into the field chosen by bits [7:6]. Field k lives at `cfg_regs[6k+5:6k]`, and the other fields keep their values.
- R3: The configuration fields do not change on FIFO writes, FIFO reads, status reads or stream traffic.
- R4: Each FIFO-mode write strobe pushes exactly one byte. The bytes leave on `tx_data` in the order they were written.
- R5: A FIFO-mode write while the transmit FIFO holds TX_DEPTH bytes is dropped and sets the sticky transmit-overflow flag.
- R6: While the strobe is active, a FIFO-mode read drives the oldest receive byte. Its release pops exactly that byte.
- R7: A FIFO-mode read of an empty receive FIFO returns 8'h00 and leaves the FIFO unchanged.
- R8: The status byte has transmit full in bit 0, transmit empty in bit 1, receive empty in bit 2, receive overflow in bit 3 and transmit overflow in bit 4. Bits 7:5 are zero.
- R9: Both overflow flags are sticky. A status read clears them at its strobe release.
- R10: `bus_oe` is high only while `sel_n` is low and `rd_wr` is high.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R12: `rx_ready` is low while the receive FIFO holds RX_DEPTH bytes. A beat offered then is dropped and sets the receive-overflow flag.
- R13: A write takes effect on the third rising clock edge after `sel_n` rises. The strobe must stay low for at least three clocks and high for at least three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low host select strobe |
| rd_wr | input | 1 | 1 = host read, 0 = host write |
| fifo_sel | input | 1 | 1 = FIFO access, 0 = register/status access |
| bus_din | input | 8 | Data from the host pads |
| bus_dout | output | 8 | Data to the host pads |
| bus_oe | output | 1 | Pad output enable |
| tx_valid | output | 1 | Transmit stream beat available |
| tx_ready | input | 1 | Engine accepts transmit beat |
| tx_data | output | 8 | Transmit stream byte |
| rx_valid | input | 1 | Engine offers receive beat |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Receive stream byte |
| cfg_regs | output | 24 | Four 6-bit configuration fields |

## Verification
A wrong pointer or count in either FIFO shows up within one host access. The next FIFO read returns a byte out of order or returns zero when data is waiting, and the next status read shows a full or empty bit that disagrees with the number of bytes pushed and popped. A bad strobe edge detector pushes a byte twice or not at all, so `tx_valid` or the drained sequence is off by one on the third edge after release. A sticky flag that is lost or never cleared differs from expectation on the next status read.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int FIELD_W  = BUS_W - ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam int ST_TX_FULL  = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_RX_EMPTY = 2;
  localparam int ST_RX_OVF   = 3;
  localparam int ST_TX_OVF   = 4;

  typedef struct packed {
    logic             rd;
    logic             fifo;
    logic [BUS_W-1:0] data;
  } host_beat_t;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync
  import hostbus_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             rd_wr,
  input  logic             fifo_sel,
  input  logic [BUS_W-1:0] din,
  output logic             evt,
  output host_beat_t       evt_beat
);
  logic [STAGES-1:0] sel_q;
  host_beat_t        beat_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '1;
      for (int i = 0; i < STAGES; i++) beat_q[i] <= '0;
    end else begin
      sel_q[0]  <= sel_n;
      beat_q[0] <= '{rd: rd_wr, fifo: fifo_sel, data: din};
      for (int i = 1; i < STAGES; i++) begin
        sel_q[i]  <= sel_q[i-1];
        beat_q[i] <= beat_q[i-1];
      end
    end
  end

  assign evt      = sel_q[STAGES-2] & ~sel_q[STAGES-1];
  assign evt_beat = beat_q[STAGES-1];
endmodule

// File: rtl/hostbus_fifo.sv
module hostbus_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wdata;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hostbus_regs.sv
module hostbus_regs
  import hostbus_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [FIELD_W-1:0]          value,
  output logic [NUM_REGS*FIELD_W-1:0] fields
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        fields[k*FIELD_W +: FIELD_W] <= '0;
      else if (wr_en && addr == ADDR_W'(k))
        fields[k*FIELD_W +: FIELD_W] <= value;
    end
  end
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hostbus_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_n,
  input  logic                        rd_wr,
  input  logic                        fifo_sel,
  input  logic [BUS_W-1:0]            bus_din,
  output logic [BUS_W-1:0]            bus_dout,
  output logic                        bus_oe,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [BUS_W-1:0]            tx_data,
  input  logic                        rx_valid,
  output logic                        rx_ready,
  input  logic [BUS_W-1:0]            rx_data,
  output logic [NUM_REGS*FIELD_W-1:0] cfg_regs
);
  logic       evt;
  host_beat_t beat;
  logic       wr_fifo_evt, rd_fifo_evt, wr_reg_evt, rd_stat_evt;
  logic       tx_full, tx_empty, tx_push, tx_pop;
  logic       rx_full, rx_empty, rx_push, rx_pop;
  logic [BUS_W-1:0] rx_head;
  logic       tx_ovf_q, rx_ovf_q;
  logic [BUS_W-1:0] status;

  hostbus_sync #(.STAGES(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
    .fifo_sel(fifo_sel), .din(bus_din), .evt(evt), .evt_beat(beat)
  );

  assign wr_fifo_evt = evt & ~beat.rd &  beat.fifo;
  assign rd_fifo_evt = evt &  beat.rd &  beat.fifo;
  assign wr_reg_evt  = evt & ~beat.rd & ~beat.fifo;
  assign rd_stat_evt = evt &  beat.rd & ~beat.fifo;

  assign tx_push  = wr_fifo_evt & ~tx_full;
  assign tx_valid = ~tx_empty;
  assign tx_pop   = tx_valid & tx_ready;

  hostbus_fifo #(.WIDTH(BUS_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(beat.data),
    .pop(tx_pop), .head(tx_data), .full(tx_full), .empty(tx_empty)
  );

  assign rx_ready = ~rx_full;
  assign rx_push  = rx_valid & ~rx_full;
  assign rx_pop   = rd_fifo_evt & ~rx_empty;

  hostbus_fifo #(.WIDTH(BUS_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_data),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  hostbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_reg_evt),
    .addr(beat.data[BUS_W-1 -: ADDR_W]), .value(beat.data[FIELD_W-1:0]),
    .fields(cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else begin
      if (wr_fifo_evt && tx_full) tx_ovf_q <= 1'b1;
      else if (rd_stat_evt)       tx_ovf_q <= 1'b0;
      if (rx_valid && rx_full)    rx_ovf_q <= 1'b1;
      else if (rd_stat_evt)       rx_ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_TX_FULL]  = tx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_RX_OVF]   = rx_ovf_q;
    status[ST_TX_OVF]   = tx_ovf_q;
  end

  assign bus_oe = ~sel_n & rd_wr;

  always_comb begin
    if (!bus_oe)       bus_dout = '0;
    else if (fifo_sel) bus_dout = rx_empty ? '0 : rx_head;
    else               bus_dout = status;
  end
endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
  parameter int CFG_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic [CFG_W-1:0] cfg_regs,
  input logic             wr_reg_evt,
  input logic             wr_fifo_evt,
  input logic             rd_fifo_evt,
  input logic             rd_stat_evt,
  input logic             tx_ovf_q,
  input logic             rx_ovf_q,
  input logic             rx_empty,
  input logic             rx_push
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reg_evt |=> $stable(cfg_regs)); // R3

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_reg_evt, wr_fifo_evt, rd_fifo_evt, rd_stat_evt})); // R13

  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_q && !rd_stat_evt |=> tx_ovf_q); // R9

  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_q && !rd_stat_evt |=> rx_ovf_q); // R12

  AST_RX_EMPTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && !rx_push |=> rx_empty); // R7
endmodule

bind hostbus_bridge hostbus_bridge_chk #(.CFG_W(hostbus_pkg::NUM_REGS*hostbus_pkg::FIELD_W)) u_chk (.*);

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rd_wr = 1'b0, fifo_sel = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic bus_oe, tx_valid, rx_ready;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic [7:0] rx_data = '0;
  logic [23:0] cfg_regs;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [5:0] m_cfg [4];
  bit m_txovf = 0, m_rxovf = 0;

  always #10 clk = ~clk;

  hostbus_bridge #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {3'b000, m_txovf, m_rxovf, rxq.size() == 0, txq.size() == 0, txq.size() == TXD};
  endfunction

  function automatic logic [23:0] exp_cfg();
    return {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]};
  endfunction

  task automatic host_write(input bit fifo, input logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b0; fifo_sel = fifo; bus_din = d;
    repeat (3) @(negedge clk);
    chk("R10 oe during write", bus_oe, 1'b0);
    sel_n = 1'b1; bus_din = ~d;
    repeat (4) @(negedge clk);
    if (fifo) begin
      if (txq.size() < TXD) txq.push_back(d); else m_txovf = 1;
    end else m_cfg[d[7:6]] = d[5:0];
  endtask

  task automatic host_read(input bit fifo, output logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b1; fifo_sel = fifo;
    repeat (2) @(negedge clk);
    chk("R10 oe during read", bus_oe, 1'b1);
    d = bus_dout;
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    chk("R10 oe idle", bus_oe, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_fifo_check();
    logic [7:0] d, e;
    e = (rxq.size() == 0) ? 8'h00 : rxq[0];
    host_read(1'b1, d);
    if (rxq.size() == 0) chk("R7 empty read", d, 8'h00);
    else begin chk("R6 rx order", d, e); void'(rxq.pop_front()); end
  endtask

  task automatic read_status_check();
    logic [7:0] d;
    host_read(1'b0, d);
    chk("R8 status", d, exp_status());
    m_txovf = 0; m_rxovf = 0;
  endtask

  task automatic offer_rx(input logic [7:0] d);
    @(negedge clk);
    chk("R12 rx_ready", rx_ready, rxq.size() < RXD);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
    if (rxq.size() < RXD) rxq.push_back(d); else m_rxovf = 1;
  endtask

  task automatic drain_one();
    @(negedge clk);
    chk("R11 tx_valid", tx_valid, txq.size() > 0);
    if (txq.size() > 0) begin
      chk("R4 tx order", tx_data, txq[0]);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      void'(txq.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg zero", cfg_regs, 24'h0);
    chk("R1 tx_valid", tx_valid, 1'b0);
    chk("R10 idle oe", bus_oe, 1'b0);
    read_status_check();
    chk("R1 status value", exp_status(), 8'h06);

    host_write(1'b0, {2'd2, 6'h2b});
    chk("R2 field 2", cfg_regs, exp_cfg());
    host_write(1'b0, {2'd0, 6'h3f});
    chk("R2 field 0", cfg_regs, exp_cfg());

    // R13: push lands on the third rising edge after release
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b0; fifo_sel = 1'b1; bus_din = 8'hA5;
    repeat (3) @(negedge clk);
    sel_n = 1'b1; bus_din = 8'h00;
    repeat (2) @(negedge clk);
    chk("R13 not before edge 3", tx_valid, 1'b0);
    @(negedge clk);
    chk("R13 at edge 3", tx_valid, 1'b1);
    repeat (2) @(negedge clk);
    txq.push_back(8'hA5);

    // R11 stall hold
    held = tx_data;
    repeat (5) @(negedge clk);
    chk("R11 data held", tx_data, held);
    chk("R3 cfg after fifo write", cfg_regs, exp_cfg());

    // R5 overflow of transmit FIFO
    for (int i = 1; i <= TXD; i++) host_write(1'b1, 8'(i * 17));
    chk("R5 queue size", txq.size(), TXD);
    chk("R5 flag model", m_txovf, 1'b1);
    read_status_check();
    read_status_check(); // R9 flag now cleared
    while (txq.size() > 0) drain_one();
    drain_one();

    // R7 empty read leaves FIFO intact, then R6 order
    read_fifo_check();
    offer_rx(8'h3C);
    offer_rx(8'hC3);
    read_fifo_check();
    read_fifo_check();
    read_fifo_check();

    // R12 receive overflow
    for (int i = 0; i <= RXD; i++) offer_rx(8'(i + 8'h40));
    read_status_check();
    while (rxq.size() > 0) read_fifo_check();
    chk("R3 cfg kept", cfg_regs, exp_cfg());

    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin host_write(1'b0, 8'($urandom)); chk("R2 random", cfg_regs, exp_cfg()); end
        1: host_write(1'b1, 8'($urandom));
        2: offer_rx(8'($urandom));
        3: read_fifo_check();
        4: read_status_check();
        default: drain_one();
      endcase
    end
    chk("R3 final cfg", cfg_regs, exp_cfg());
    read_status_check();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule